// File: doc/BRIEF.md
# Bus Error Monitor with First-Error Capture

This block watches several internal buses at once and judges every single access on each of them. Two faults are recognised. An address-valid strobe that arrives while no region-select line is asserted is an illegal-address error. An accepted access whose acknowledge does not come back within a programmable number of cycles is a timeout error. Each beat of a burst carries its own strobe and acknowledge, so each beat is judged as an access of its own.

The first fault is frozen in a status record. The record holds one illegal bit and one timeout bit per bus, plus the master number that issued the faulting access on each bus. Faults that arrive while the record is held change nothing. Faults on several buses in the same cycle set several bits together.

Software reads the record through a single-cycle register port. It clears the record by writing 1 to a self-clearing bit in the control register, which re-arms capture. A level interrupt stays high while the record holds a fault and the monitor is enabled.

Each bus has a tracker state machine with the states `TRK_IDLE` and `TRK_WAIT`:
- `TRK_IDLE` goes to `TRK_WAIT` on a strobe with a region hit and no acknowledge in the same cycle.
- `TRK_WAIT` goes back to `TRK_IDLE` on an acknowledge, on timeout expiry, or on a strobe that misses every region.
- A new hitting strobe while in `TRK_WAIT` stays in `TRK_WAIT` and restarts the count.

The capture state machine has the states `CAP_ARMED` and `CAP_HELD`:
- `CAP_ARMED` goes to `CAP_HELD` when any fault arrives without a clear.
- Either state goes to `CAP_ARMED` on a clear.

Top module: `bus_err_monitor`

## Requirements
- R1: A strobe with no region select on bus b sets the illegal bit of bus b. The illegal bits sit at status-1 (address 2) bits [NB-1:0], and the bit is visible on the cycle after the strobe.
- R2: After a hitting strobe in cycle t, an acknowledge in any cycle t..t+LIMIT raises no fault. With no acknowledge by t+LIMIT, the timeout bit of the bus is set; timeout bits sit at status-1 bits [8+NB-1:8]. A late acknowledge after that is ignored.
- R3: Every beat of a burst is judged on its own. One missing region select among good beats flags the burst, and beats before it flag nothing.
- R4: On capture, status-2 (address 3) holds the master number of each faulting bus in bits [4b+MW-1:4b], and 0 for buses without a fault. The master number of a timeout is the one given with the access's strobe.
- R5: Once a fault is captured, later faults change neither status register until a clear.
- R6: Faults on several buses in the same cycle set all of their bits and master fields together.
- R7: Writing 1 to control bit 1 (address 0) clears both status registers and re-arms capture. Control bit 1 always reads 0.
- R8: A fault that arrives in the same cycle as a clear write is dropped.
- R9: The interrupt output is high exactly when control bit 0 (enable) is 1 and some status-1 bit is set.
- R10: A timeout limit of 0 disables timeout detection.
- R11: Register map: address 0 control (bit 0 enable, reset 0), address 1 timeout limit in bits [TO_W-1:0] (reset LIMIT_RST), readable and writable. The status registers are read-only, and all unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | NB | Address-valid strobe per bus, one cycle per access |
| bus_hit | input | NB | Any region select asserted, per bus, sampled with the strobe |
| bus_ack | input | NB | Access acknowledge per bus |
| bus_mst | input | NB*MW | Master number per bus, valid with the strobe |
| reg_addr | input | 2 | Register address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| irq | output | 1 | Level interrupt to the CPU |

## Verification
Illegal strobes are swept over every bus and every master number. This separates the bus bit positions and shows that each master field lands in its own slot. Acknowledge delays are swept from 0 to one past the limit for limits 1 to 5, which pins down the exact cycle where an acceptable late acknowledge becomes a timeout. The remaining patterns each isolate one rule:
- a burst with a single bad beat;
- two buses faulting together;
- a fault after capture;
- a fault on the very cycle of a clear;
- a zero limit with a hung access.

// File: rtl/bem_pkg.sv
package bem_pkg;
    typedef enum logic {TRK_IDLE, TRK_WAIT} trk_state_e;
    typedef enum logic {CAP_ARMED, CAP_HELD} cap_state_e;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_LIMIT = 2'd1;
    localparam logic [1:0] ADDR_STAT1 = 2'd2;
    localparam logic [1:0] ADDR_STAT2 = 2'd3;

    localparam int unsigned CTRL_EN_BIT  = 0;
    localparam int unsigned CTRL_CLR_BIT = 1;
    localparam int unsigned TO_FIELD_LSB = 8;
    localparam int unsigned MST_STRIDE   = 4;
endpackage

// File: rtl/bem_tracker.sv
module bem_tracker
    import bem_pkg::*;
#(
    parameter int unsigned MW   = 2,
    parameter int unsigned TO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic            hit,
    input  logic            ack,
    input  logic [MW-1:0]   mst,
    input  logic [TO_W-1:0] limit,
    output logic            err_ill,
    output logic            err_to,
    output logic [MW-1:0]   err_mst
);
    localparam logic [TO_W-1:0] ONE = TO_W'(1);

    trk_state_e      state_q, state_d;
    logic [TO_W-1:0] cnt_q, cnt_d;
    logic [MW-1:0]   mst_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TRK_IDLE;
            cnt_q   <= '0;
            mst_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (req) mst_q <= mst;
        end
    end

    // outputs
    always_comb begin
        err_ill = req & ~hit;
        err_to  = (state_q == TRK_WAIT) && !req && !ack &&
                  (limit != '0) && (cnt_q >= limit - ONE);
        err_mst = req ? mst : mst_q;
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TRK_IDLE: begin
                if (req && hit && !ack) begin
                    state_d = TRK_WAIT;
                    cnt_d   = '0;
                end
            end
            TRK_WAIT: begin
                if (req) begin
                    if (hit && !ack) cnt_d = '0;
                    else             state_d = TRK_IDLE;
                end else if (ack || err_to) begin
                    state_d = TRK_IDLE;
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end
            default: state_d = TRK_IDLE;
        endcase
    end

    // R2: a timeout always closes the access
    p_idle_after_to_r2: assert property (@(posedge clk) disable iff (!rst_n)
        err_to |=> (state_q == TRK_IDLE));
endmodule

// File: rtl/bem_capture.sv
module bem_capture
    import bem_pkg::*;
#(
    parameter int unsigned NB = 2,
    parameter int unsigned MW = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [NB-1:0]    err_ill,
    input  logic [NB-1:0]    err_to,
    input  logic [NB*MW-1:0] err_mst,
    output logic [NB-1:0]    ill_q,
    output logic [NB-1:0]    to_q,
    output logic [NB*MW-1:0] mst_q,
    output logic             held
);
    cap_state_e       state_q, state_d;
    logic             any_err;
    logic [NB*MW-1:0] mst_mask;

    assign any_err = |{err_ill, err_to};

    generate
        for (genvar b = 0; b < NB; b++) begin : g_mask
            assign mst_mask[b*MW +: MW] = (err_ill[b] | err_to[b]) ?
                                          err_mst[b*MW +: MW] : '0;
        end
    endgenerate

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_ARMED: if (!clr && any_err) state_d = CAP_HELD;
            CAP_HELD:  if (clr)             state_d = CAP_ARMED;
            default:   state_d = CAP_ARMED;
        endcase
    end

    // state register and record
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CAP_ARMED;
            ill_q   <= '0;
            to_q    <= '0;
            mst_q   <= '0;
        end else begin
            state_q <= state_d;
            if (clr) begin
                ill_q <= '0;
                to_q  <= '0;
                mst_q <= '0;
            end else if (state_q == CAP_ARMED && any_err) begin
                ill_q <= err_ill;
                to_q  <= err_to;
                mst_q <= mst_mask;
            end
        end
    end

    // outputs
    always_comb held = (state_q == CAP_HELD);

    // R1: an unselected strobe while armed is captured
    p_ill_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CAP_ARMED && !clr && |err_ill) |=> held);
    // R5: a held record does not move without a clear
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !clr) |=> ($stable(ill_q) && $stable(to_q) && $stable(mst_q)));
    // R8: a clear always leaves an empty record
    p_clr_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ill_q == '0 && to_q == '0 && !held));
    // R6: the held state and a nonzero record go together
    p_held_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        held == (|{ill_q, to_q}));
endmodule

// File: rtl/bem_regs.sv
module bem_regs
    import bem_pkg::*;
#(
    parameter int unsigned     NB        = 2,
    parameter int unsigned     MW        = 2,
    parameter int unsigned     TO_W      = 16,
    parameter logic [TO_W-1:0] LIMIT_RST = TO_W'(64)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_addr,
    input  logic             reg_we,
    input  logic [31:0]      reg_wdata,
    input  logic [NB-1:0]    ill,
    input  logic [NB-1:0]    to,
    input  logic [NB*MW-1:0] mst,
    output logic [31:0]      reg_rdata,
    output logic             en,
    output logic [TO_W-1:0]  limit,
    output logic             clr
);
    logic [31:0] stat1, stat2;

    assign clr = reg_we && (reg_addr == ADDR_CTRL) && reg_wdata[CTRL_CLR_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en    <= 1'b0;
            limit <= LIMIT_RST;
        end else if (reg_we) begin
            if (reg_addr == ADDR_CTRL)  en    <= reg_wdata[CTRL_EN_BIT];
            if (reg_addr == ADDR_LIMIT) limit <= reg_wdata[TO_W-1:0];
        end
    end

    always_comb begin
        stat1 = 32'(ill) | (32'(to) << TO_FIELD_LSB);
        stat2 = '0;
        for (int b = 0; b < NB; b++)
            stat2[b*MST_STRIDE +: MW] = mst[b*MW +: MW];
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_CTRL:  reg_rdata = 32'(en);
            ADDR_LIMIT: reg_rdata = 32'(limit);
            ADDR_STAT1: reg_rdata = stat1;
            ADDR_STAT2: reg_rdata = stat2;
            default:    reg_rdata = '0;
        endcase
    end

    // R7: the clear bit never reads back as 1
    p_clr_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_CTRL) |-> !reg_rdata[CTRL_CLR_BIT]);
endmodule

// File: rtl/bus_err_monitor.sv
module bus_err_monitor
    import bem_pkg::*;
#(
    parameter int unsigned     NB        = 2,
    parameter int unsigned     MW        = 2,
    parameter int unsigned     TO_W      = 16,
    parameter logic [TO_W-1:0] LIMIT_RST = TO_W'(64)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NB-1:0]    bus_req,
    input  logic [NB-1:0]    bus_hit,
    input  logic [NB-1:0]    bus_ack,
    input  logic [NB*MW-1:0] bus_mst,
    input  logic [1:0]       reg_addr,
    input  logic             reg_we,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             irq
);
    logic [NB-1:0]    err_ill, err_to, ill_q, to_q;
    logic [NB*MW-1:0] err_mst, mst_q;
    logic             en, clr, held;
    logic [TO_W-1:0]  limit;

    generate
        for (genvar b = 0; b < NB; b++) begin : g_bus
            bem_tracker #(.MW(MW), .TO_W(TO_W)) u_trk (
                .clk     (clk),
                .rst_n   (rst_n),
                .req     (bus_req[b]),
                .hit     (bus_hit[b]),
                .ack     (bus_ack[b]),
                .mst     (bus_mst[b*MW +: MW]),
                .limit   (limit),
                .err_ill (err_ill[b]),
                .err_to  (err_to[b]),
                .err_mst (err_mst[b*MW +: MW])
            );
        end
    endgenerate

    bem_capture #(.NB(NB), .MW(MW)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .err_ill (err_ill),
        .err_to  (err_to),
        .err_mst (err_mst),
        .ill_q   (ill_q),
        .to_q    (to_q),
        .mst_q   (mst_q),
        .held    (held)
    );

    bem_regs #(.NB(NB), .MW(MW), .TO_W(TO_W), .LIMIT_RST(LIMIT_RST)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .ill       (ill_q),
        .to        (to_q),
        .mst       (mst_q),
        .reg_rdata (reg_rdata),
        .en        (en),
        .limit     (limit),
        .clr       (clr)
    );

    assign irq = en & held;

    // R9: interrupt follows enable and recorded faults
    p_irq_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (en && (|{ill_q, to_q})));
endmodule

// File: tb/bus_err_monitor_bench.sv
`timescale 1ns/1ps
module bus_err_monitor_bench;
    localparam int NB = 2;
    localparam int MW = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NB-1:0]    bus_req = '0, bus_hit = '0, bus_ack = '0;
    logic [NB*MW-1:0] bus_mst = '0;
    logic [1:0]       reg_addr = '0;
    logic             reg_we = 1'b0;
    logic [31:0]      reg_wdata = '0;
    logic [31:0]      reg_rdata;
    logic             irq;
    int               checks = 0, errors = 0;
    bit               done = 1'b0;

    always #2.5 clk = ~clk;

    bus_err_monitor #(.NB(NB), .MW(MW)) u_bus_err_monitor (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_hit(bus_hit),
        .bus_ack(bus_ack), .bus_mst(bus_mst), .reg_addr(reg_addr),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_we = 1'b1; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    // one access: delay 0 = acknowledge with strobe; ack sent delay cycles after strobe
    task automatic acc(input int b, input int m, input bit h, input int d);
        @(negedge clk);
        bus_req[b] = 1'b1; bus_hit[b] = h; bus_mst[b*MW +: MW] = MW'(m);
        bus_ack[b] = (h && d == 0);
        @(negedge clk);
        bus_req[b] = 1'b0; bus_ack[b] = 1'b0; bus_hit[b] = 1'b0;
        if (h && d > 0) begin
            repeat (d - 1) @(negedge clk);
            bus_ack[b] = 1'b1;
            @(negedge clk);
            bus_ack[b] = 1'b0;
        end
    endtask

    function automatic logic [31:0] mfield(input int b, input int m);
        return 32'(m) << (4 * b);
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        rd(2'd0, v); chk("R11 ctrl reset", v, 32'h0);
        rd(2'd1, v); chk("R11 limit reset", v, 32'd64);
        rd(2'd2, v); chk("R11 stat1 reset", v, 32'h0);
        rd(2'd3, v); chk("R11 stat2 reset", v, 32'h0);
        chk("R9 irq reset", {31'b0, irq}, 32'h0);
        wr(2'd1, 32'hFFFF_1234); rd(2'd1, v); chk("R11 limit rw", v, 32'h1234);
        wr(2'd0, 32'h3); rd(2'd0, v); chk("R7 clear bit reads 0", v, 32'h1);

        // R1 R4 illegal sweep over buses and masters
        for (int b = 0; b < NB; b++)
            for (int m = 0; m < 4; m++) begin
                wr(2'd0, 32'h3);
                acc(b, m, 1'b0, 0);
                rd(2'd2, v); chk("R1 illegal bit", v, 32'(1) << b);
                rd(2'd3, v); chk("R4 master field", v, mfield(b, m));
                chk("R9 irq on", {31'b0, irq}, 32'h1);
            end

        // R2 timeout sweep over limits and acknowledge delays
        for (int lim = 1; lim <= 5; lim++) begin
            wr(2'd1, 32'(lim));
            for (int d = 0; d <= lim + 1; d++) begin
                int b = (lim + d) % NB;
                int m = (lim * 3 + d) % 4;
                wr(2'd0, 32'h3);
                acc(b, m, 1'b1, d);
                repeat (2) @(negedge clk);
                rd(2'd2, v);
                chk("R2 timeout bit", v, (d > lim) ? (32'(1) << (8 + b)) : 32'h0);
                rd(2'd3, v);
                chk("R4 timeout master", v, (d > lim) ? mfield(b, m) : 32'h0);
            end
        end

        // R3 burst with one bad beat
        wr(2'd1, 32'd4);
        wr(2'd0, 32'h3);
        acc(0, 2, 1'b1, 1); acc(0, 2, 1'b1, 2);
        rd(2'd2, v); chk("R3 good beats clean", v, 32'h0);
        acc(0, 2, 1'b0, 0); acc(0, 2, 1'b1, 1);
        rd(2'd2, v); chk("R3 bad beat flagged", v, 32'h1);
        rd(2'd3, v); chk("R3 bad beat master", v, mfield(0, 2));

        // R5 freeze
        acc(1, 3, 1'b0, 0);
        rd(2'd2, v); chk("R5 stat1 frozen", v, 32'h1);
        rd(2'd3, v); chk("R5 stat2 frozen", v, mfield(0, 2));

        // R9 enable gating
        wr(2'd0, 32'h0);
        chk("R9 irq masked", {31'b0, irq}, 32'h0);
        wr(2'd0, 32'h1);
        chk("R9 irq unmasked", {31'b0, irq}, 32'h1);

        // R6 simultaneous faults
        wr(2'd0, 32'h3);
        @(negedge clk);
        bus_req = 2'b11; bus_hit = 2'b00; bus_mst = {2'd1, 2'd3};
        @(negedge clk);
        bus_req = '0;
        rd(2'd2, v); chk("R6 both bits", v, 32'h3);
        rd(2'd3, v); chk("R6 both masters", v, mfield(0, 3) | mfield(1, 1));

        // R8 clear in same cycle as a fault
        @(negedge clk);
        reg_addr = 2'd0; reg_we = 1'b1; reg_wdata = 32'h3;
        bus_req[0] = 1'b1; bus_hit[0] = 1'b0; bus_mst[1:0] = 2'd2;
        @(negedge clk);
        reg_we = 1'b0; bus_req[0] = 1'b0;
        rd(2'd2, v); chk("R8 fault dropped", v, 32'h0);
        chk("R8 irq low", {31'b0, irq}, 32'h0);
        acc(1, 2, 1'b0, 0);
        rd(2'd2, v); chk("R7 rearmed", v, 32'h2);
        rd(2'd3, v); chk("R7 rearmed master", v, mfield(1, 2));

        // R10 zero limit disables timeout
        wr(2'd1, 32'd0);
        wr(2'd0, 32'h3);
        @(negedge clk); bus_req[0] = 1'b1; bus_hit[0] = 1'b1; bus_mst[1:0] = 2'd1;
        @(negedge clk); bus_req[0] = 1'b0; bus_hit[0] = 1'b0;
        repeat (40) @(negedge clk);
        rd(2'd2, v); chk("R10 no timeout", v, 32'h0);
        chk("R10 irq low", {31'b0, irq}, 32'h0);
        bus_ack[0] = 1'b1; @(negedge clk); bus_ack[0] = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule